// File: doc/BRIEF.md
# Downstream Command Frame Packer and Unpacker

This block forms the downstream direction of a serial link between a memory host and a buffer placed in front of DRAM devices. The host side packs one 120-bit frame for every DRAM clock period and sends it as twelve consecutive 10-bit transfers on ten lanes. A frame holds three 36-bit slots (A, B, C), a one-bit kind flag and an 11-bit CRC. In command kind, each slot carries a command or a no-op. In write kind, slot A carries a command and slots B and C together carry a 72-bit chunk of write data. Two write-kind frames deliver the 18 bytes that one DRAM command clock moves.

When nothing is offered at the frame boundary, the packer sends an idle frame instead. An idle frame has a no-op in every slot and a correct CRC, so the receiver always sees a stream of well-formed frames. The buffer-side unpacker collects the twelve transfers after a frame-start strobe and recomputes the CRC. It then reports the slot contents with per-slot valid flags, or flags a CRC error and withholds all valids.

The transmit lanes and the receive lanes are separate ports. A system connects them through the physical link. A test can connect them directly, or corrupt the path between them.

Top module: `sbf_link`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tx_start` is 1, `in_ready` is 0, `tx_lanes` carries transfer 0 of the idle frame, and `rx_frame_ok`/`rx_crc_error` are 0. The first frame sent after reset is an idle frame.
- R2: Frames are sent back to back, each taking 12 cycles. In transfer k (k = 0..11), `tx_lanes[9:0]` equals frame bits [10k+9:10k]. `tx_start` is 1 in transfer 0 only.
- R3: `in_ready` is 1 only during transfer 11. A request is taken only when `in_valid` and `in_ready` are both 1, and it is sent as the very next frame. A request held valid only while `in_ready` is 0 has no effect: the next frame is idle.
- R4: Frame layout: slot A is bits [35:0], slot B is [71:36], slot C is [107:72], the kind flag is bit 108 (0 = command, 1 = write data), and the CRC is [119:109].
- R5: The CRC is computed over bits [108:0], bit 108 first. It uses the generator x^11+x^9+x^8+x^7+x^2+1 (0x385), a seed of 0x7FF, and no final inversion.
- R6: In command kind, slot n (n = 0,1,2 for A,B,C) carries `in_slot_a/b/c` when `in_mask[n]` is 1, and the no-op code (all zeros) when it is 0.
- R7: In write kind, slot A follows `in_mask[0]` as in R6, slot B carries `in_wdata[35:0]`, slot C carries `in_wdata[71:36]`, and `in_mask[2:1]`, `in_slot_b` and `in_slot_c` are ignored.
- R8: An idle frame is command kind with the no-op code in all three slots and a CRC per R5.
- R9: In the cycle after receiving transfer 11 of a frame with a correct CRC, `rx_frame_ok` pulses for one cycle. In that cycle `rx_slot_a/b/c`, `rx_kind` and `rx_wdata = {slot C, slot B}` show the frame. `rx_slot_vld[n]` is 1 for a non-no-op slot, counting slots B and C only in command kind, and `rx_wdata_vld` is 1 for write kind.
- R10: When the received CRC does not match, `rx_crc_error` pulses for one cycle at that same point, and `rx_frame_ok`, `rx_slot_vld` and `rx_wdata_vld` stay 0.
- R11: An `rx_start` during a partly received frame discards the collected transfers and starts a new frame from that transfer. The discarded frame produces neither `rx_frame_ok` nor `rx_crc_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one transfer per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame request is offered |
| in_ready | output | 1 | Request is taken this cycle (transfer 11) |
| in_kind | input | 1 | 0 = command frame, 1 = write-data frame |
| in_mask | input | 3 | Per-slot command enable (bit 0 = A) |
| in_slot_a | input | 36 | Command for slot A |
| in_slot_b | input | 36 | Command for slot B (command kind) |
| in_slot_c | input | 36 | Command for slot C (command kind) |
| in_wdata | input | 72 | Write-data chunk (write kind) |
| tx_lanes | output | 10 | Transmit lanes, one transfer per cycle |
| tx_start | output | 1 | Marks transfer 0 on the transmit side |
| rx_lanes | input | 10 | Receive lanes |
| rx_start | input | 1 | Marks transfer 0 on the receive side |
| rx_frame_ok | output | 1 | One-cycle pulse for a frame with a good CRC |
| rx_crc_error | output | 1 | One-cycle pulse for a frame with a bad CRC |
| rx_kind | output | 1 | Kind flag of the received frame |
| rx_slot_vld | output | 3 | Valid command in slot A/B/C |
| rx_slot_a | output | 36 | Received slot A |
| rx_slot_b | output | 36 | Received slot B |
| rx_slot_c | output | 36 | Received slot C |
| rx_wdata | output | 72 | Received write data {slot C, slot B} |
| rx_wdata_vld | output | 1 | Received frame carries write data |

## Verification
The assertions assume that the inputs are only meaningful when `in_valid` and `in_ready` are both high. They also assume that the receive side sees either its own transmit stream or a deliberately damaged copy, so received frames always start at least twelve cycles apart. The stimulus follows this. It changes request inputs only at falling edges. It feeds `rx_lanes`/`rx_start` from the transmit outputs, with a bit flip or an extra start strobe added on a single chosen transfer. It also holds `in_valid` high only during non-ready transfers when it tests that such requests are dropped.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int LANES   = 10;
    localparam int BEATS   = 12;
    localparam int SLOTS   = 3;
    localparam int SLOT_W  = 36;
    localparam int CRC_W   = 11;
    localparam int WDATA_W = 2 * SLOT_W;
    localparam int FRAME_W = LANES * BEATS;
    localparam int BODY_W  = FRAME_W - CRC_W;

    localparam logic [CRC_W-1:0]  CRC_POLY = 11'h385;
    localparam logic [CRC_W-1:0]  CRC_SEED = 11'h7FF;
    localparam logic [SLOT_W-1:0] NOP_CMD  = '0;

    typedef enum logic {
        KIND_CMD   = 1'b0,
        KIND_WDATA = 1'b1
    } frame_kind_e;

    // Bit order of the packed struct is the on-wire frame layout.
    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic              kind;
        logic [SLOT_W-1:0] slot_c;
        logic [SLOT_W-1:0] slot_b;
        logic [SLOT_W-1:0] slot_a;
    } sb_frame_t;

    // Serial CRC, most significant body bit first.
    function automatic logic [CRC_W-1:0] crc_calc(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = CRC_SEED;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ body[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

    function automatic sb_frame_t seal_frame(input logic kind,
                                             input logic [SLOT_W-1:0] a,
                                             input logic [SLOT_W-1:0] b,
                                             input logic [SLOT_W-1:0] c);
        sb_frame_t f;
        f.kind   = kind;
        f.slot_a = a;
        f.slot_b = b;
        f.slot_c = c;
        f.crc    = crc_calc({kind, c, b, a});
        return f;
    endfunction

    localparam sb_frame_t IDLE_FRAME = seal_frame(1'b0, NOP_CMD, NOP_CMD, NOP_CMD);

endpackage

// File: rtl/sbf_frame_build.sv
module sbf_frame_build
    import sbf_pkg::*;
(
    input  logic                kind,
    input  logic [SLOTS-1:0]    mask,
    input  logic [SLOT_W-1:0]   slot_a,
    input  logic [SLOT_W-1:0]   slot_b,
    input  logic [SLOT_W-1:0]   slot_c,
    input  logic [WDATA_W-1:0]  wdata,
    output sb_frame_t           frame
);

    frame_kind_e       kind_w;
    logic [SLOT_W-1:0] raw  [SLOTS];
    logic [SLOT_W-1:0] eff  [SLOTS];

    assign kind_w = frame_kind_e'(kind);

    // Slots B and C switch to write data in write kind.
    assign raw[0] = slot_a;
    assign raw[1] = (kind_w == KIND_WDATA) ? wdata[SLOT_W-1:0]       : slot_b;
    assign raw[2] = (kind_w == KIND_WDATA) ? wdata[WDATA_W-1:SLOT_W] : slot_c;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_cmd_only
            assign eff[s] = mask[s] ? raw[s] : NOP_CMD;
        end else begin : g_shared
            assign eff[s] = (mask[s] || (kind_w == KIND_WDATA)) ? raw[s] : NOP_CMD;
        end
    end

    assign frame = seal_frame(kind, eff[0], eff[1], eff[2]);

endmodule

// File: rtl/sbf_serializer.sv
module sbf_serializer #(
    parameter int LANES = sbf_pkg::LANES,
    parameter int BEATS = sbf_pkg::BEATS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES*BEATS-1:0]   next_frame,
    input  logic                     next_valid,
    output logic                     load_slot,
    output logic [LANES-1:0]         lanes,
    output logic                     start
);

    localparam int FW = LANES * BEATS;
    localparam int CW = $clog2(BEATS);
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    logic [FW-1:0] idle_w;
    logic [FW-1:0] frame_q;
    logic [CW-1:0] beat_q;

    assign idle_w = sbf_pkg::IDLE_FRAME;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            frame_q <= idle_w;
        end else if (beat_q == LAST) begin
            beat_q  <= '0;
            frame_q <= next_valid ? next_frame : idle_w;
        end else begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    assign load_slot = (beat_q == LAST);
    assign start     = (beat_q == '0);
    assign lanes     = frame_q[int'(beat_q) * LANES +: LANES];

endmodule

// File: rtl/sbf_deserializer.sv
module sbf_deserializer #(
    parameter int LANES = sbf_pkg::LANES,
    parameter int BEATS = sbf_pkg::BEATS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         lanes,
    input  logic                     start,
    output logic [LANES*BEATS-1:0]   frame,
    output logic                     done
);

    localparam int FW = LANES * BEATS;
    localparam int CW = $clog2(BEATS);
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    logic [FW-1:0] buf_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                // A start always restarts collection, even mid-frame.
                buf_q[LANES-1:0] <= lanes;
                cnt_q            <= CW'(1);
                active_q         <= 1'b1;
            end else if (active_q) begin
                buf_q[int'(cnt_q) * LANES +: LANES] <= lanes;
                if (cnt_q == LAST) begin
                    cnt_q    <= '0;
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign frame = buf_q;
    assign done  = done_q;

endmodule

// File: rtl/sbf_frame_check.sv
module sbf_frame_check
    import sbf_pkg::*;
(
    input  sb_frame_t            frame,
    input  logic                 done,
    output logic                 frame_ok,
    output logic                 crc_error,
    output logic                 kind,
    output logic [SLOTS-1:0]     slot_vld,
    output logic [SLOT_W-1:0]    slot_a,
    output logic [SLOT_W-1:0]    slot_b,
    output logic [SLOT_W-1:0]    slot_c,
    output logic [WDATA_W-1:0]   wdata,
    output logic                 wdata_vld
);

    frame_kind_e       kind_w;
    logic              crc_ok;
    logic              good;
    logic [SLOT_W-1:0] slot_w [SLOTS];

    assign kind_w = frame_kind_e'(frame.kind);
    assign crc_ok = (frame.crc == crc_calc({frame.kind, frame.slot_c, frame.slot_b, frame.slot_a}));
    assign good   = done && crc_ok;

    assign slot_w[0] = frame.slot_a;
    assign slot_w[1] = frame.slot_b;
    assign slot_w[2] = frame.slot_c;

    for (genvar s = 0; s < SLOTS; s++) begin : g_vld
        if (s == 0) begin : g_cmd_only
            assign slot_vld[s] = good && (slot_w[s] != NOP_CMD);
        end else begin : g_shared
            assign slot_vld[s] = good && (kind_w == KIND_CMD) && (slot_w[s] != NOP_CMD);
        end
    end

    assign frame_ok  = good;
    assign crc_error = done && !crc_ok;
    assign kind      = frame.kind;
    assign slot_a    = frame.slot_a;
    assign slot_b    = frame.slot_b;
    assign slot_c    = frame.slot_c;
    assign wdata     = {frame.slot_c, frame.slot_b};
    assign wdata_vld = good && (kind_w == KIND_WDATA);

endmodule

// File: rtl/sbf_link.sv
module sbf_link
    import sbf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_kind,
    input  logic [2:0]           in_mask,
    input  logic [35:0]          in_slot_a,
    input  logic [35:0]          in_slot_b,
    input  logic [35:0]          in_slot_c,
    input  logic [71:0]          in_wdata,
    output logic [9:0]           tx_lanes,
    output logic                 tx_start,
    input  logic [9:0]           rx_lanes,
    input  logic                 rx_start,
    output logic                 rx_frame_ok,
    output logic                 rx_crc_error,
    output logic                 rx_kind,
    output logic [2:0]           rx_slot_vld,
    output logic [35:0]          rx_slot_a,
    output logic [35:0]          rx_slot_b,
    output logic [35:0]          rx_slot_c,
    output logic [71:0]          rx_wdata,
    output logic                 rx_wdata_vld
);

    sb_frame_t            tx_frame;
    logic [FRAME_W-1:0]   rx_bits;
    sb_frame_t            rx_frame;
    logic                 rx_done;

    sbf_frame_build u_build (
        .kind   (in_kind),
        .mask   (in_mask),
        .slot_a (in_slot_a),
        .slot_b (in_slot_b),
        .slot_c (in_slot_c),
        .wdata  (in_wdata),
        .frame  (tx_frame)
    );

    sbf_serializer #(.LANES(LANES), .BEATS(BEATS)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .next_frame (tx_frame),
        .next_valid (in_valid),
        .load_slot  (in_ready),
        .lanes      (tx_lanes),
        .start      (tx_start)
    );

    sbf_deserializer #(.LANES(LANES), .BEATS(BEATS)) u_deser (
        .clk   (clk),
        .rst   (rst),
        .lanes (rx_lanes),
        .start (rx_start),
        .frame (rx_bits),
        .done  (rx_done)
    );

    assign rx_frame = rx_bits;

    sbf_frame_check u_check (
        .frame     (rx_frame),
        .done      (rx_done),
        .frame_ok  (rx_frame_ok),
        .crc_error (rx_crc_error),
        .kind      (rx_kind),
        .slot_vld  (rx_slot_vld),
        .slot_a    (rx_slot_a),
        .slot_b    (rx_slot_b),
        .slot_c    (rx_slot_c),
        .wdata     (rx_wdata),
        .wdata_vld (rx_wdata_vld)
    );

endmodule

// File: rtl/sbf_link_chk.sv
module sbf_link_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_kind,
    input logic        mask0,
    input logic [9:0]  slot_a_lo,
    input logic [9:0]  tx_lanes,
    input logic        tx_start,
    input logic        rx_frame_ok,
    input logic        rx_crc_error,
    input logic        rx_kind,
    input logic [2:0]  rx_slot_vld,
    input logic        rx_wdata_vld
);

    logic [9:0] idle_lo;
    assign idle_lo = sbf_pkg::IDLE_FRAME[9:0];

    assert_ready_one_beat_R3: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    assert_start_after_ready_R2: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> tx_start);

    assert_start_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !in_ready);

    assert_idle_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (tx_lanes == idle_lo));

    assert_wdata_slot_a_R7: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid && in_kind && mask0) |=> (tx_lanes == $past(slot_a_lo)));

    assert_crc_suppress_R10: assert property (@(posedge clk) disable iff (rst)
        rx_crc_error |-> (!rx_frame_ok && (rx_slot_vld == 3'b000) && !rx_wdata_vld));

    assert_ok_single_R9: assert property (@(posedge clk) disable iff (rst)
        rx_frame_ok |=> (!rx_frame_ok && !rx_crc_error));

    assert_wdata_kind_R9: assert property (@(posedge clk) disable iff (rst)
        rx_wdata_vld |-> (rx_frame_ok && rx_kind));

endmodule

bind sbf_link sbf_link_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_kind      (in_kind),
    .mask0        (in_mask[0]),
    .slot_a_lo    (in_slot_a[9:0]),
    .tx_lanes     (tx_lanes),
    .tx_start     (tx_start),
    .rx_frame_ok  (rx_frame_ok),
    .rx_crc_error (rx_crc_error),
    .rx_kind      (rx_kind),
    .rx_slot_vld  (rx_slot_vld),
    .rx_wdata_vld (rx_wdata_vld)
);

// File: tb/sbf_link_tb.sv
module sbf_link_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_kind = 1'b0;
    logic [2:0]  in_mask = '0;
    logic [35:0] in_slot_a = '0, in_slot_b = '0, in_slot_c = '0;
    logic [71:0] in_wdata = '0;
    logic [9:0]  tx_lanes, rx_lanes;
    logic        tx_start, rx_start;
    logic        rx_frame_ok, rx_crc_error, rx_kind, rx_wdata_vld;
    logic [2:0]  rx_slot_vld;
    logic [35:0] rx_slot_a, rx_slot_b, rx_slot_c;
    logic [71:0] rx_wdata;
    logic [9:0]  flip = '0;
    logic        inj_start = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    assign rx_lanes = tx_lanes ^ flip;
    assign rx_start = tx_start | inj_start;

    sbf_link u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_mask(in_mask), .in_slot_a(in_slot_a),
        .in_slot_b(in_slot_b), .in_slot_c(in_slot_c), .in_wdata(in_wdata),
        .tx_lanes(tx_lanes), .tx_start(tx_start), .rx_lanes(rx_lanes),
        .rx_start(rx_start), .rx_frame_ok(rx_frame_ok), .rx_crc_error(rx_crc_error),
        .rx_kind(rx_kind), .rx_slot_vld(rx_slot_vld), .rx_slot_a(rx_slot_a),
        .rx_slot_b(rx_slot_b), .rx_slot_c(rx_slot_c), .rx_wdata(rx_wdata),
        .rx_wdata_vld(rx_wdata_vld)
    );

    // {kind, mask[2:0], slot_a, slot_b, slot_c, wdata}
    localparam logic [183:0] VECS [6] = '{
        {1'b0, 3'b111, 36'h1_2345_6789, 36'hA_BCDE_F012, 36'h5_5AA5_33CC, 72'h0},
        {1'b0, 3'b101, 36'hF_0000_0001, 36'h7_7777_7777, 36'h8_0000_0000, 72'h0},
        {1'b1, 3'b001, 36'h3_0C0C_0C0C, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 72'hDE_ADBE_EF01_2345_6789},
        {1'b1, 3'b000, 36'h9_9999_9999, 36'h1_1111_1111, 36'h2_2222_2222, 72'hFF_FFFF_FFFF_FFFF_FFFF},
        {1'b0, 3'b010, 36'hC_0000_0000, 36'h0_0000_0001, 36'h6_0000_0000, 72'h0},
        {1'b0, 3'b000, 36'h4_4444_4444, 36'h5_5555_5555, 36'h6_6666_6666, 72'h0}
    };

    // R5: generator 0x385, seed 0x7FF, body bit 108 first.
    function automatic logic [10:0] ref_crc(input logic [108:0] d);
        logic [10:0] c = 11'h7FF;
        for (int i = 108; i >= 0; i--) begin
            logic fb = c[10] ^ d[i];
            c = {c[9:0], 1'b0};
            if (fb) c = c ^ 11'h385;
        end
        return c;
    endfunction

    // R4/R6/R7 layout from the requirements.
    function automatic logic [119:0] ref_frame(input logic [183:0] v);
        logic        k = v[183];
        logic [2:0]  m = v[182:180];
        logic [35:0] a = m[0] ? v[179:144] : 36'h0;
        logic [35:0] b = k ? v[35:0]  : (m[1] ? v[143:108] : 36'h0);
        logic [35:0] c = k ? v[71:36] : (m[2] ? v[107:72]  : 36'h0);
        logic [108:0] body = {k, c, b, a};
        return {ref_crc(body), body};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic drive(input logic [183:0] v);
        in_valid  = 1'b1;
        in_kind   = v[183];
        in_mask   = v[182:180];
        in_slot_a = v[179:144];
        in_slot_b = v[143:108];
        in_slot_c = v[107:72];
        in_wdata  = v[71:0];
    endtask

    // Starts at the falling edge showing transfer 0; ends at transfer 11.
    // mode 1: flip a bit on transfer arg; mode 2: extra start on transfer arg;
    // mode 3: hold hv valid during transfers 1..9 only.
    task automatic collect(input logic [119:0] expf, input int mode, input int arg,
                           input logic [183:0] hv, input string tag);
        logic [119:0] got = '0;
        bit start_ok = 1'b1;
        bit ready_ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            flip      = '0;
            inj_start = 1'b0;
            got[k*10 +: 10] = tx_lanes;
            if (tx_start != (k == 0)) start_ok = 1'b0;
            if (in_ready != (k == 11)) ready_ok = 1'b0;
            if (mode == 1 && k == arg) flip = 10'h004;
            if (mode == 2 && k == arg) inj_start = 1'b1;
            if (mode == 3) begin
                if (k == 1) drive(hv);
                if (k == 10) in_valid = 1'b0;
            end
        end
        chk(got == expf, {tag, " R4 R5 frame bits on lanes"}, 128'(got), 128'(expf));
        chk(start_ok, "R2 tx_start only on transfer 0", 128'(start_ok), 128'(1));
        chk(ready_ok, "R3 in_ready only on transfer 11", 128'(ready_ok), 128'(1));
    endtask

    // expect: 0 good frame f, 1 crc error, 2 nothing reported
    task automatic rx_check(input logic [119:0] f, input int expect_kind);
        logic [2:0] ev;
        @(negedge clk);
        flip      = '0;
        inj_start = 1'b0;
        in_valid  = 1'b0;
        ev[0] = (f[35:0] != 36'h0);
        ev[1] = !f[108] && (f[71:36] != 36'h0);
        ev[2] = !f[108] && (f[107:72] != 36'h0);
        if (expect_kind == 0) begin
            chk(rx_frame_ok && !rx_crc_error, "R9 frame_ok pulse",
                128'({rx_frame_ok, rx_crc_error}), 128'(2'b10));
            chk(rx_slot_vld == ev, "R9 slot valids", 128'(rx_slot_vld), 128'(ev));
            chk({rx_kind, rx_slot_c, rx_slot_b, rx_slot_a} == f[108:0], "R9 slot contents",
                128'({rx_kind, rx_slot_c, rx_slot_b, rx_slot_a}), 128'(f[108:0]));
            chk(rx_wdata_vld == f[108] && (!f[108] || rx_wdata == f[107:36]), "R9 write data",
                128'({rx_wdata_vld, rx_wdata}), 128'({f[108], f[107:36]}));
        end else if (expect_kind == 1) begin
            chk(rx_crc_error && !rx_frame_ok, "R10 crc_error pulse",
                128'({rx_frame_ok, rx_crc_error}), 128'(2'b01));
            chk(rx_slot_vld == 3'b000 && !rx_wdata_vld, "R10 valids suppressed",
                128'({rx_slot_vld, rx_wdata_vld}), 128'(0));
        end else begin
            chk(!rx_frame_ok && !rx_crc_error, "R11 discarded frame silent",
                128'({rx_frame_ok, rx_crc_error}), 128'(0));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [119:0] idle = ref_frame(184'h0);
        logic [119:0] prev;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_start && !in_ready && !rx_frame_ok && !rx_crc_error, "R1 reset outputs",
            128'({tx_start, in_ready, rx_frame_ok, rx_crc_error}), 128'(4'b1000));
        chk(tx_lanes == idle[9:0], "R1 R8 reset lanes idle", 128'(tx_lanes), 128'(idle[9:0]));
        rst = 1'b0;

        // R1: first frame idle; valid offered only while not ready (R3).
        collect(idle, 3, 0, VECS[0], "R1 R8 first idle");
        rx_check(idle, 0);
        collect(idle, 0, 0, '0, "R3 ignored request gives idle");
        prev = idle;

        // Table walk.
        for (int i = 0; i < 6; i++) begin
            drive(VECS[i]);
            rx_check(prev, 0);
            prev = ref_frame(VECS[i]);
            collect(prev, 0, 0, '0, VECS[i][183] ? "R7 write frame" : "R6 command frame");
        end

        // R10: corrupt a payload transfer, then the CRC field of an idle frame.
        drive(VECS[0]);
        rx_check(prev, 0);
        collect(ref_frame(VECS[0]), 1, 7, '0, "R10 payload flip");
        rx_check('0, 1);
        collect(idle, 1, 11, '0, "R10 R5 crc field flip");
        drive(VECS[2]);
        rx_check('0, 1);

        // R11: stray start mid-frame.
        collect(ref_frame(VECS[2]), 2, 5, '0, "R11 stray start");
        rx_check('0, 2);
        collect(idle, 0, 0, '0, "R11 recovery idle");
        rx_check(idle, 0);

        finish_run();
    end

endmodule